// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a one-to-one registered buffer for the command and address path of a memory module. On each rising clock edge it registers 21 data bits, a pair of active-low chip selects, a pair of clock-enable bits and a pair of termination-control bits. Every output is driven straight from its register, so any input shows up at the outputs one clock after the edge that captured it.

The 21 data bits can be gated by chip select. When the static mode input `gate_en` is high, the data register loads only on edges where at least one chip select is active (low). When both chip selects are inactive, the data outputs keep their previous value. When `gate_en` is low, the data bits load on every edge. The chip-select, clock-enable and termination bits are never gated.

The active-low reset `rst_n` may change at any time relative to the clock. Asserting it clears every register at once. Its release passes through a two-flop synchroniser, so capture starts only on a clean edge after deassertion.

Top module: `cmdreg_top`

## Requirements
- R1: With `gate_en` = 1 and at least one bit of `cs_n_i` equal to 0 at a rising edge, `q_o` equals the `d_i` value sampled at that edge.
- R2: With `gate_en` = 1 and `cs_n_i` = 2'b11 at a rising edge, `q_o` keeps the value it held before that edge.
- R3: With `gate_en` = 0, `q_o` takes the `d_i` value sampled at every rising edge, whatever `cs_n_i` is.
- R4: `cke_o` and `odt_o` take the `cke_i` and `odt_i` values of every rising edge, whatever `gate_en` and `cs_n_i` are.
- R5: `cs_n_o` takes the `cs_n_i` value of every rising edge, including edges where both chip selects are high.
- R6: When `rst_n` falls, every output (`q_o`, `cs_n_o`, `cke_o`, `odt_o`) goes to 0 at once, with no clock edge needed.
- R7: While `rst_n` is 0, every output stays 0, whatever the clock, `gate_en` and the other inputs do, active chip selects included.
- R8: After `rst_n` rises, every output stays 0 through the first two rising edges. The third rising edge is the first one that captures inputs.
- R9: Outside reset, each output changes only at a rising edge and carries the input of that edge, with no further pipeline stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset; assertion takes effect at once, release is synchronised |
| gate_en | input | 1 | Static mode: 1 gates data loading by chip select, 0 loads data on every edge |
| cs_n_i | input | 2 | Active-low chip selects |
| cke_i | input | 2 | Clock-enable bits, never gated |
| odt_i | input | 2 | Termination-control bits, never gated |
| d_i | input | 21 | Command and address bits subject to gating |
| q_o | output | 21 | Registered data bits |
| cs_n_o | output | 2 | Registered chip selects |
| cke_o | output | 2 | Registered clock-enable bits |
| odt_o | output | 2 | Registered termination-control bits |

## Verification
The hardest situation to reach from the ports is a reset that falls in the middle of a clock period and then rises again with active chip selects and all-ones data on the inputs. A fault in the release path shows only as outputs that go nonzero one or two edges too early. The stimulus drops `rst_n` a few nanoseconds after a rising edge and samples the outputs before the next edge. While reset is held it drives ones with both chip selects active. It then releases reset on a falling edge with a fresh pattern and checks the outputs after each of the next three rising edges. The gated-hold case is reached by a run of both-high chip selects that changes the data, clock-enable and termination bits. This way a hold on the data bits is told apart from a hold on the whole register.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  localparam int unsigned DEF_DATA_W = 21;
  localparam int unsigned DEF_CS_W   = 2;
  localparam int unsigned DEF_CKE_W  = 2;
  localparam int unsigned DEF_ODT_W  = 2;
  localparam int unsigned SYNC_DEPTH = 2;

  // Load decision for the gated bank: gating disabled, or some select active.
  function automatic logic data_load_f(input logic gate_on, input logic all_idle);
    return !gate_on || !all_idle;
  endfunction

endpackage

// File: rtl/cmdreg_rst_sync.sv
module cmdreg_rst_sync #(
  parameter int unsigned DEPTH = cmdreg_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic run_n
);

  logic [DEPTH-1:0] chain_q;

  // Assertion is immediate; release ripples through DEPTH flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[DEPTH-2:0], 1'b1};
  end

  assign run_n = chain_q[DEPTH-1];

endmodule

// File: rtl/cmdreg_gate.sv
module cmdreg_gate #(
  parameter int unsigned CS_W = cmdreg_pkg::DEF_CS_W
) (
  input  logic            gate_en,
  input  logic [CS_W-1:0] cs_n,
  output logic            all_idle,
  output logic            data_load
);

  assign all_idle  = &cs_n;
  assign data_load = cmdreg_pkg::data_load_f(gate_en, all_idle);

endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank #(
  parameter int unsigned WIDTH = 1,
  parameter bit          GATED = 1'b0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      if (GATED) begin : g_en
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n)   q[b] <= 1'b0;
          else if (load) q[b] <= d[b];
        end
      end else begin : g_free
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) q[b] <= 1'b0;
          else         q[b] <= d[b];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top #(
  parameter int unsigned DATA_W = cmdreg_pkg::DEF_DATA_W,
  parameter int unsigned CS_W   = cmdreg_pkg::DEF_CS_W,
  parameter int unsigned CKE_W  = cmdreg_pkg::DEF_CKE_W,
  parameter int unsigned ODT_W  = cmdreg_pkg::DEF_ODT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [CS_W-1:0]   cs_n_i,
  input  logic [CKE_W-1:0]  cke_i,
  input  logic [ODT_W-1:0]  odt_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic [CS_W-1:0]   cs_n_o,
  output logic [CKE_W-1:0]  cke_o,
  output logic [ODT_W-1:0]  odt_o
);

  localparam int unsigned SIDE_W = CS_W + CKE_W + ODT_W;

  // Named internal events, visible to the bound checker.
  logic run_n;
  logic all_idle;
  logic data_load;

  logic [SIDE_W-1:0] side_d;
  logic [SIDE_W-1:0] side_q;

  cmdreg_rst_sync #(.DEPTH(cmdreg_pkg::SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .run_n  (run_n)
  );

  cmdreg_gate #(.CS_W(CS_W)) u_gate (
    .gate_en   (gate_en),
    .cs_n      (cs_n_i),
    .all_idle  (all_idle),
    .data_load (data_load)
  );

  cmdreg_bank #(.WIDTH(DATA_W), .GATED(1'b1)) u_data (
    .clk    (clk),
    .arst_n (run_n),
    .load   (data_load),
    .d      (d_i),
    .q      (q_o)
  );

  assign side_d = {cs_n_i, cke_i, odt_i};

  cmdreg_bank #(.WIDTH(SIDE_W), .GATED(1'b0)) u_side (
    .clk    (clk),
    .arst_n (run_n),
    .load   (1'b1),
    .d      (side_d),
    .q      (side_q)
  );

  assign cs_n_o = side_q[SIDE_W-1 -: CS_W];
  assign cke_o  = side_q[ODT_W +: CKE_W];
  assign odt_o  = side_q[ODT_W-1:0];

endmodule

// File: rtl/cmdreg_chk.sv
module cmdreg_chk #(
  parameter int unsigned DATA_W = cmdreg_pkg::DEF_DATA_W,
  parameter int unsigned CS_W   = cmdreg_pkg::DEF_CS_W,
  parameter int unsigned CKE_W  = cmdreg_pkg::DEF_CKE_W,
  parameter int unsigned ODT_W  = cmdreg_pkg::DEF_ODT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic [CS_W-1:0]   cs_n_i,
  input logic [CKE_W-1:0]  cke_i,
  input logic [ODT_W-1:0]  odt_i,
  input logic [DATA_W-1:0] d_i,
  input logic [DATA_W-1:0] q_o,
  input logic [CS_W-1:0]   cs_n_o,
  input logic [CKE_W-1:0]  cke_o,
  input logic [ODT_W-1:0]  odt_o,
  input logic              run_n,
  input logic              data_load
);

  // R1
  selected_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && gate_en && !(&cs_n_i)) |=> (q_o == $past(d_i)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && gate_en && (&cs_n_i)) |=> $stable(q_o));

  // R3
  ungated_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && !gate_en) |=> (q_o == $past(d_i)));

  // R4
  sideband_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> (cke_o == $past(cke_i) && odt_o == $past(odt_i)));

  // R5
  select_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> (cs_n_o == $past(cs_n_i)));

  // R6 R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (q_o == '0 && cs_n_o == '0 && cke_o == '0 && odt_o == '0));

  // R8
  release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_n) |-> ($past(rst_n, 1) && $past(rst_n, 2)));

  // R8
  startup_zero_chk: assert property (@(posedge clk)
    !run_n |-> (q_o == '0 && cs_n_o == '0 && cke_o == '0 && odt_o == '0));

  // R9
  load_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && !data_load) |=> (q_o == $past(q_o)));

endmodule

bind cmdreg_top cmdreg_chk #(
  .DATA_W (DATA_W),
  .CS_W   (CS_W),
  .CKE_W  (CKE_W),
  .ODT_W  (ODT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_en   (gate_en),
  .cs_n_i    (cs_n_i),
  .cke_i     (cke_i),
  .odt_i     (odt_i),
  .d_i       (d_i),
  .q_o       (q_o),
  .cs_n_o    (cs_n_o),
  .cke_o     (cke_o),
  .odt_o     (odt_o),
  .run_n     (run_n),
  .data_load (data_load)
);

// File: tb/cmdreg_top_tb.sv
module cmdreg_top_tb;

  localparam int DW = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          gate_en;
  logic [1:0]    cs_n_i, cke_i, odt_i;
  logic [DW-1:0] d_i;
  logic [DW-1:0] q_o;
  logic [1:0]    cs_n_o, cke_o, odt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_q;
  logic [DW-1:0] exp_d_q[$];
  logic [5:0]    exp_s_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  cmdreg_top u_dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n_i(cs_n_i),
    .cke_i(cke_i), .odt_i(odt_i), .d_i(d_i), .q_o(q_o),
    .cs_n_o(cs_n_o), .cke_o(cke_o), .odt_o(odt_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] exp_d, input logic [5:0] exp_s);
    checks++;
    if (q_o !== exp_d || {cs_n_o, cke_o, odt_o} !== exp_s) begin
      errors++;
      $display("FAIL %s: q=%h side=%b, expected q=%h side=%b",
               tag, q_o, {cs_n_o, cke_o, odt_o}, exp_d, exp_s);
    end
  endtask

  // Driver: apply on the falling edge, queue the result due after the next rising edge.
  task automatic step(input string tag, input logic g, input logic [1:0] cs,
                      input logic [1:0] ck, input logic [1:0] od, input logic [DW-1:0] d);
    @(negedge clk);
    gate_en = g; cs_n_i = cs; cke_i = ck; odt_i = od; d_i = d;
    if (!g || cs != 2'b11) m_q = d;
    @(posedge clk);
    exp_d_q.push_back(m_q);
    exp_s_q.push_back({cs, ck, od});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare at the falling edge after the capturing edge.
  always @(negedge clk) begin
    if (exp_d_q.size() > 0) begin
      logic [DW-1:0] ed;
      logic [5:0]    es;
      string         t;
      ed = exp_d_q.pop_front();
      es = exp_s_q.pop_front();
      t  = tag_q.pop_front();
      check(t, ed, es);
    end
  end

  task automatic drain();
    while (exp_d_q.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; gate_en = 1'b1; cs_n_i = 2'b11; cke_i = '0; odt_i = '0; d_i = '0;
    m_q = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset state", '0, 6'b0);

    // R8: release with all-ones inputs and active selects
    gate_en = 1'b1; cs_n_i = 2'b00; cke_i = 2'b11; odt_i = 2'b11; d_i = '1;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 first edge after release", '0, 6'b0);
    @(posedge clk); @(negedge clk);
    check("R8 second edge after release", '0, 6'b0);
    @(posedge clk); @(negedge clk);
    check("R8 third edge captures", '1, 6'b001111);
    m_q = '1;

    step("R1 cs0 active",        1'b1, 2'b10, 2'b01, 2'b10, 21'h0A5A5A);
    step("R1 cs1 active",        1'b1, 2'b01, 2'b10, 2'b01, 21'h15A5A5);
    step("R2 idle hold",         1'b1, 2'b11, 2'b11, 2'b00, 21'h1FFFFF);
    step("R2 idle hold again",   1'b1, 2'b11, 2'b00, 2'b11, 21'h000000);
    step("R4 sideband while idle", 1'b1, 2'b11, 2'b01, 2'b01, 21'h123456);
    step("R5 selects re-driven", 1'b1, 2'b00, 2'b10, 2'b10, 21'h0F0F0F);
    step("R3 ungated idle",      1'b0, 2'b11, 2'b00, 2'b01, 21'h1C3C3C);
    step("R3 ungated active",    1'b0, 2'b00, 2'b11, 2'b10, 21'h03C3C3);
    step("R3 ungated idle 2",    1'b0, 2'b11, 2'b10, 2'b00, 21'h155555);
    step("R2 gating back on",    1'b1, 2'b11, 2'b01, 2'b11, 21'h0AAAAA);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] h;
      h = (i + 1) * 32'h9E3779B1;
      step("R9 mixed stream", h[0] | h[1], h[3:2], h[5:4], h[7:6], h[28:8]);
    end
    drain();

    // R6: asynchronous assertion mid-period
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1 check("R6 async clear", '0, 6'b0);
    m_q = '0;

    // R7: reset wins over active selects and ungated mode
    @(negedge clk);
    gate_en = 1'b0; cs_n_i = 2'b00; cke_i = 2'b11; odt_i = 2'b11; d_i = '1;
    @(posedge clk); @(negedge clk);
    check("R7 reset priority", '0, 6'b0);
    gate_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 reset priority gated", '0, 6'b0);

    // R8 again after a mid-run reset
    d_i = 21'h0BEEF5; cs_n_i = 2'b01; cke_i = 2'b10; odt_i = 2'b01;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 hold low edge 1", '0, 6'b0);
    @(posedge clk); @(negedge clk);
    check("R8 hold low edge 2", '0, 6'b0);
    @(posedge clk); @(negedge clk);
    check("R8 capture edge 3", 21'h0BEEF5, 6'b011001);
    m_q = 21'h0BEEF5;

    step("R2 hold after restart", 1'b1, 2'b11, 2'b00, 2'b00, 21'h000111);
    step("R1 load after restart", 1'b1, 2'b10, 2'b11, 2'b11, 21'h000222);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule